// File: doc/BRIEF.md
# SIMD Branch Divergence Mask Stack

This block tracks which lanes of a 32-lane warp are active while the warp runs in lockstep through code that contains data-dependent branches. Each lane supplies a one-bit predicate with a branch. When the active lanes disagree, the block saves a reconvergence record on a hardware stack and restricts the warp to the lanes that took the branch. At the next convergence marker it switches to the lanes that fell through. At the marker after that it pops the record and restores the enclosing mask at the reconvergence PC. All lanes step through both paths. Only lanes whose bit is set in the active mask commit their results.

When the active lanes all agree, nothing is pushed and the warp simply redirects to the single path. The block also owns the fetch PC. A plain step advances it by one instruction. Branches and markers load it with the target, fall-through or reconvergence address.

Top module: `simt_mask_stack`

## Requirements
- R1: After a synchronous active-high reset the active mask is all ones, the fetch PC equals RESET_PC, the overflow flag is low and the stack holds no records.
- R2: A step event advances the fetch PC by STEP bytes and leaves the active mask unchanged.
- R3: A branch whose predicate is 1 on every active lane moves the fetch PC to the taken target, leaves the mask unchanged and pushes nothing.
- R4: A branch whose predicate is 0 on every active lane moves the fetch PC to the fall-through address, leaves the mask unchanged and pushes nothing.
- R5: A divergent branch (predicate 1 on some active lanes and 0 on others) makes the next active mask equal to predicate AND mask, and makes the fetch PC the taken target.
- R6: The first convergence marker after a divergence makes the mask equal to the lanes of the enclosing mask whose predicate was 0, and makes the fetch PC the fall-through address.
- R7: The second convergence marker after a divergence restores the enclosing mask and makes the fetch PC the reconvergence address.
- R8: Divergences nest in last-in, first-out order up to DEPTH levels.
- R9: A divergent branch that arrives while DEPTH records are held sets the overflow flag. The flag stays set until reset. That branch leaves the mask and the fetch PC unchanged.
- R10: A convergence marker that arrives while the stack is empty has no effect on the mask or the fetch PC.
- R11: Predicate bits of inactive lanes do not affect whether a branch is uniform or divergent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Branch event this cycle |
| br_pred | input | LANES | Per-lane branch predicate, 1 means taken |
| br_taken_pc | input | PCW | Taken target address |
| br_fall_pc | input | PCW | Fall-through address |
| br_reconv_pc | input | PCW | Address where both paths rejoin |
| mark_valid | input | 1 | Convergence marker reached |
| step_valid | input | 1 | Sequential advance of the fetch PC |
| active_mask | output | LANES | Lanes allowed to commit results |
| fetch_pc | output | PCW | Address to fetch next |
| overflow | output | 1 | Sticky flag: a push was refused because the stack was full |

## Verification
The assertions assume that at most one of br_valid, mark_valid and step_valid is high in any cycle, and that markers arrive in the pairs that well-nested code produces. The stimulus drives exactly one event per call of its drive task, and it issues markers only in matched pairs, apart from deliberate markers on an empty stack. Nesting depth is raised to exactly DEPTH before the single overflowing branch is sent. Predicates always leave at least one active lane on each side of a divergent branch, so the active mask never becomes empty.

// File: rtl/simt_pkg.sv
package simt_pkg;
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_STEP   = 2'd1,
    EV_BRANCH = 2'd2,
    EV_MARK   = 2'd3
  } ev_e;
endpackage

// File: rtl/lane_split.sv
module lane_split #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0] pred,
  input  logic [LANES-1:0] act,
  output logic [LANES-1:0] tk_mask,
  output logic [LANES-1:0] nt_mask,
  output logic             any_tk,
  output logic             any_nt
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign tk_mask[i] = act[i] &  pred[i];
    assign nt_mask[i] = act[i] & ~pred[i];
  end
  assign any_tk = |tk_mask;
  assign any_nt = |nt_mask;
endmodule

// File: rtl/recon_stack.sv
module recon_stack #(
  parameter int W     = 128,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_rec,
  input  logic         flip,
  input  logic         pop,
  output logic [W-1:0] top_rec,
  output logic         top_done,
  output logic         empty,
  output logic         full
);
  localparam int PTRW = $clog2(DEPTH + 1);
  localparam int IDXW = $clog2(DEPTH);

  logic [W-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] done_q;
  logic [PTRW-1:0] cnt;
  logic [PTRW-1:0] top_ptr;
  logic [IDXW-1:0] top_idx;
  logic [IDXW-1:0] wr_idx;

  assign top_ptr = cnt - PTRW'(1);
  assign top_idx = top_ptr[IDXW-1:0];
  assign wr_idx  = cnt[IDXW-1:0];
  assign empty   = (cnt == '0);
  assign full    = (cnt == PTRW'(DEPTH));
  assign top_rec = mem[top_idx];
  assign top_done = done_q[top_idx];

  always_ff @(posedge clk) begin
    if (push) mem[wr_idx] <= push_rec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      done_q <= '0;
    end else if (push) begin
      cnt            <= cnt + PTRW'(1);
      done_q[wr_idx] <= 1'b0;
    end else if (flip) begin
      done_q[top_idx] <= 1'b1;
    end else if (pop) begin
      cnt <= top_ptr;
    end
  end

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
    full |-> !push); // R9
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    empty |-> !(pop || flip)); // R10
  AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (rst)
    push |=> !empty); // R8
  AST_POP_AFTER_FLIP: assert property (@(posedge clk) disable iff (rst)
    (flip && !push) |=> top_done); // R6
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
  import simt_pkg::*;
#(
  parameter int LANES    = 32,
  parameter int PCW      = 32,
  parameter int DEPTH    = 8,
  parameter int STEP     = 4,
  parameter int RESET_PC = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_pred,
  input  logic [PCW-1:0]   br_taken_pc,
  input  logic [PCW-1:0]   br_fall_pc,
  input  logic [PCW-1:0]   br_reconv_pc,
  input  logic             mark_valid,
  input  logic             step_valid,
  output logic [LANES-1:0] active_mask,
  output logic [PCW-1:0]   fetch_pc,
  output logic             overflow
);
  // record layout: {reconv_pc, outer_mask, else_pc, else_mask}
  localparam int REC_W   = 2 * (PCW + LANES);
  localparam int EMSK_LO = 0;
  localparam int EPC_LO  = LANES;
  localparam int OMSK_LO = LANES + PCW;
  localparam int RPC_LO  = 2 * LANES + PCW;

  logic [LANES-1:0] tk_mask, nt_mask;
  logic             any_tk, any_nt, diverge;
  ev_e              ev;
  logic             st_push, st_flip, st_pop, st_empty, st_full, st_done;
  logic [REC_W-1:0] push_rec, top_rec;
  logic [LANES-1:0] mask_d;
  logic [PCW-1:0]   pc_d;
  logic             ovf_d;

  lane_split #(.LANES(LANES)) u_split (
    .pred(br_pred), .act(active_mask),
    .tk_mask(tk_mask), .nt_mask(nt_mask),
    .any_tk(any_tk), .any_nt(any_nt)
  );

  assign diverge = any_tk & any_nt;

  always_comb begin
    if (br_valid)        ev = EV_BRANCH;
    else if (mark_valid) ev = EV_MARK;
    else if (step_valid) ev = EV_STEP;
    else                 ev = EV_NONE;
  end

  assign push_rec = {br_reconv_pc, active_mask, br_fall_pc, nt_mask};
  assign st_push  = (ev == EV_BRANCH) && diverge && !st_full;
  assign st_flip  = (ev == EV_MARK) && !st_empty && !st_done;
  assign st_pop   = (ev == EV_MARK) && !st_empty &&  st_done;

  recon_stack #(.W(REC_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst),
    .push(st_push), .push_rec(push_rec),
    .flip(st_flip), .pop(st_pop),
    .top_rec(top_rec), .top_done(st_done),
    .empty(st_empty), .full(st_full)
  );

  always_comb begin
    mask_d = active_mask;
    pc_d   = fetch_pc;
    ovf_d  = overflow;
    unique case (ev)
      EV_BRANCH: begin
        if (diverge) begin
          if (st_full) begin
            ovf_d = 1'b1;
          end else begin
            mask_d = tk_mask;
            pc_d   = br_taken_pc;
          end
        end else if (any_tk) begin
          pc_d = br_taken_pc;
        end else begin
          pc_d = br_fall_pc;
        end
      end
      EV_MARK: begin
        if (st_flip) begin
          mask_d = top_rec[EMSK_LO +: LANES];
          pc_d   = top_rec[EPC_LO  +: PCW];
        end else if (st_pop) begin
          mask_d = top_rec[OMSK_LO +: LANES];
          pc_d   = top_rec[RPC_LO  +: PCW];
        end
      end
      EV_STEP: pc_d = fetch_pc + PCW'(STEP);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_mask <= '1;
      fetch_pc    <= PCW'(RESET_PC);
      overflow    <= 1'b0;
    end else begin
      active_mask <= mask_d;
      fetch_pc    <= pc_d;
      overflow    <= ovf_d;
    end
  end

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
    $countones({br_valid, mark_valid, step_valid}) <= 1); // R2
  AST_MASK_LIVE: assert property (@(posedge clk) disable iff (rst)
    active_mask != '0); // R5
  AST_DIVERGE_NARROWS: assert property (@(posedge clk) disable iff (rst)
    (br_valid && diverge && !st_full) |=>
      (((active_mask & ~$past(active_mask)) == '0) && (active_mask != $past(active_mask)))); // R5
  AST_UNIFORM_KEEP: assert property (@(posedge clk) disable iff (rst)
    (br_valid && !diverge) |=> $stable(active_mask)); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R9
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (br_valid && diverge && st_full) |=> ($stable(active_mask) && $stable(fetch_pc) && overflow)); // R9
  AST_EMPTY_MARK: assert property (@(posedge clk) disable iff (rst)
    (mark_valid && st_empty) |=> ($stable(active_mask) && $stable(fetch_pc))); // R10
endmodule

// File: tb/sim_simt_mask_stack.sv
module sim_simt_mask_stack;
  localparam int LANES = 32;
  localparam int PCW   = 32;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic br_valid = 1'b0, mark_valid = 1'b0, step_valid = 1'b0;
  logic [LANES-1:0] br_pred = '0;
  logic [PCW-1:0] br_taken_pc = '0, br_fall_pc = '0, br_reconv_pc = '0;
  logic [LANES-1:0] active_mask;
  logic [PCW-1:0] fetch_pc;
  logic overflow;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  simt_mask_stack #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH), .STEP(4), .RESET_PC(0)) u0 (
    .clk(clk), .rst(rst), .br_valid(br_valid), .br_pred(br_pred),
    .br_taken_pc(br_taken_pc), .br_fall_pc(br_fall_pc), .br_reconv_pc(br_reconv_pc),
    .mark_valid(mark_valid), .step_valid(step_valid),
    .active_mask(active_mask), .fetch_pc(fetch_pc), .overflow(overflow)
  );

  // kind: 1 step, 2 branch, 3 marker
  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] pred;
    logic [31:0] tpc;
    logic [31:0] fpc;
    logic [31:0] rpc;
    logic [31:0] emask;
    logic [31:0] epc;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 32'h0,        32'h0,   32'h0,   32'h0,   32'hFFFFFFFF, 32'h004, 8'd2},  // R2
    '{2'd2, 32'hFFFFFFFF, 32'h100, 32'h008, 32'h200, 32'hFFFFFFFF, 32'h100, 8'd3},  // R3
    '{2'd2, 32'h00000000, 32'h300, 32'h104, 32'h200, 32'hFFFFFFFF, 32'h104, 8'd4},  // R4
    '{2'd2, 32'h0000FFFF, 32'h400, 32'h108, 32'h500, 32'h0000FFFF, 32'h400, 8'd5},  // R5
    '{2'd1, 32'h0,        32'h0,   32'h0,   32'h0,   32'h0000FFFF, 32'h404, 8'd2},  // R2
    '{2'd2, 32'h000000FF, 32'h600, 32'h408, 32'h700, 32'h000000FF, 32'h600, 8'd8},  // R8
    '{2'd2, 32'hFFFF0000, 32'h900, 32'h604, 32'h800, 32'h000000FF, 32'h604, 8'd11}, // R11
    '{2'd3, 32'h0,        32'h0,   32'h0,   32'h0,   32'h0000FF00, 32'h408, 8'd6},  // R6
    '{2'd3, 32'h0,        32'h0,   32'h0,   32'h0,   32'h0000FFFF, 32'h700, 8'd7},  // R7
    '{2'd3, 32'h0,        32'h0,   32'h0,   32'h0,   32'hFFFF0000, 32'h108, 8'd6},  // R6
    '{2'd3, 32'h0,        32'h0,   32'h0,   32'h0,   32'hFFFFFFFF, 32'h500, 8'd7},  // R7
    '{2'd3, 32'h0,        32'h0,   32'h0,   32'h0,   32'hFFFFFFFF, 32'h500, 8'd10}  // R10
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one event at a falling edge, let one rising edge apply it, return at next falling edge
  task automatic drive(input logic [1:0] kind, input logic [31:0] pred,
                       input logic [31:0] tpc, input logic [31:0] fpc, input logic [31:0] rpc);
    br_valid     = (kind == 2'd2);
    mark_valid   = (kind == 2'd3);
    step_valid   = (kind == 2'd1);
    br_pred      = pred;
    br_taken_pc  = tpc;
    br_fall_pc   = fpc;
    br_reconv_pc = rpc;
    @(posedge clk);
    @(negedge clk);
    br_valid = 1'b0; mark_valid = 1'b0; step_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] m;
    @(negedge clk);
    do_reset();
    // R1: reset state
    chk("R1 mask", active_mask, 32'hFFFFFFFF);
    chk("R1 pc", fetch_pc, 32'h0);
    chk("R1 ovf", {31'b0, overflow}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].kind, TBL[i].pred, TBL[i].tpc, TBL[i].fpc, TBL[i].rpc);
      chk($sformatf("R%0d vec%0d mask", TBL[i].req, i), active_mask, TBL[i].emask);
      chk($sformatf("R%0d vec%0d pc", TBL[i].req, i), fetch_pc, TBL[i].epc);
    end

    // R8: nest to full depth; branch k peels lane k off into the else side
    do_reset();
    m = 32'hFFFFFFFF;
    for (int k = 0; k < DEPTH; k++) begin
      drive(2'd2, m & ~(32'h1 << k), 32'd1000 + k*16, 32'd2000 + k*16, 32'd3000 + k*16);
      m = m & ~(32'h1 << k);
    end
    chk("R8 deepest mask", active_mask, m);
    chk("R8 deepest pc", fetch_pc, 32'd1000 + (DEPTH-1)*16);
    chk("R9 ovf low at full", {31'b0, overflow}, 32'h0);

    // R9: one more divergent branch overflows and changes nothing else
    drive(2'd2, m & ~(32'h1 << DEPTH), 32'h5000, 32'h5100, 32'h5200);
    chk("R9 ovf set", {31'b0, overflow}, 32'h1);
    chk("R9 mask kept", active_mask, m);
    chk("R9 pc kept", fetch_pc, 32'd1000 + (DEPTH-1)*16);
    drive(2'd1, 32'h0, 32'h0, 32'h0, 32'h0);
    chk("R9 ovf sticky", {31'b0, overflow}, 32'h1);

    // R8: unwind in LIFO order
    for (int k = DEPTH-1; k >= 0; k--) begin
      drive(2'd3, 32'h0, 32'h0, 32'h0, 32'h0);
      chk($sformatf("R6 level%0d mask", k), active_mask, 32'h1 << k);
      chk($sformatf("R6 level%0d pc", k), fetch_pc, 32'd2000 + k*16);
      drive(2'd3, 32'h0, 32'h0, 32'h0, 32'h0);
      chk($sformatf("R7 level%0d mask", k), active_mask, ~((32'h1 << k) - 32'h1));
      chk($sformatf("R7 level%0d pc", k), fetch_pc, 32'd3000 + k*16);
    end

    // R1: reset mid-divergence empties the stack and clears overflow
    drive(2'd2, 32'h0F0F0F0F, 32'h40, 32'h44, 32'h48);
    chk("R5 diverge before reset", active_mask, 32'h0F0F0F0F);
    do_reset();
    chk("R1 ovf cleared", {31'b0, overflow}, 32'h0);
    chk("R1 mask after reset", active_mask, 32'hFFFFFFFF);
    drive(2'd3, 32'h0, 32'h0, 32'h0, 32'h0);
    chk("R10 empty marker mask", active_mask, 32'hFFFFFFFF);
    chk("R10 empty marker pc", fetch_pc, 32'h0);

    finish_run();
  end
endmodule